// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

The block is one DMA channel. Software loads a source address, a destination address, a 24-bit unit count and a control word through a small register port. A run command then moves data one unit at a time. Each unit is a read request on the memory port followed by a write request that carries the data just read. The control word sets the unit size, from 1 to 32 bytes. It also sets, separately for the source and the destination, whether the address stays fixed, counts up or counts down by the unit size.

After every unit the engine writes the new source address, destination address and remaining count back into the channel registers. When the count reaches zero it sets the transfer-end flag in the control word. If interrupts are enabled in that word, it holds a level interrupt. A 3-bit global operation input gates the whole block. Each run command carries a unit limit, so a caller can move part of a transfer and resume it later with another run command.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset every channel register reads zero, busy_o, rd_valid_o, wr_valid_o and irq_o are 0.
- R2: Register address 0 is the source address, 1 the destination address, 2 the count (only bits [23:0] are kept, reads return zero above) and 3 the control word. Writes to addresses 0 to 2 are ignored while busy_o is 1.
- R3: run_i starts a run only when the engine is idle, glob_ctrl_i equals 3'b001 and control bits [1:0] equal 2'b01 (bit 0 enable, bit 1 transfer end). Otherwise run_i has no effect.
- R4: Control bits [6:4] select the unit size shown on unit_bytes_o: 0 gives 8, 1 gives 1, 2 gives 2, 3 gives 4 and 4 gives 32 bytes. Codes 5 to 7 give 1 byte.
- R5: Destination step mode sits in control bits [15:14] and source step mode in bits [13:12]. Value 0 is fixed, 1 adds the unit size, 2 subtracts it, and 3 is treated as fixed. The new address is stored when the unit's write handshake completes.
- R6: Each unit presents one read, with rd_valid_o and rd_addr_o held until rd_ready_i. It then presents one write to the destination address carrying the read data, held until wr_ready_i. A read and a write are never offered together.
- R7: The number of units in a run is the run limit clipped to the remaining count. A limit of 0 means run to the end of the count. A stored count of 0 means 2^24 units.
- R8: The count drops by one per completed unit. When it reaches zero, control bit 1 (transfer end) is set and the run stops.
- R9: irq_o is 1 exactly while control bit 2 (interrupt enable) and bit 1 (transfer end) are both 1. A control write that clears either bit drops irq_o.
- R10: A unit begins only if the global and channel enables hold in the cycle the previous unit's write completes. Otherwise the run ends after that unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select for read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| glob_ctrl_i | input | 3 | Global operation control, 3'b001 enables |
| run_i | input | 1 | Run command pulse |
| run_limit_i | input | 24 | Unit limit for the run, 0 = to end of count |
| rd_valid_o | output | 1 | Read request valid |
| rd_addr_o | output | 32 | Read address |
| rd_ready_i | input | 1 | Read accepted, data present |
| rd_data_i | input | 256 | Read data |
| wr_valid_o | output | 1 | Write request valid |
| wr_addr_o | output | 32 | Write address |
| wr_data_o | output | 256 | Write data |
| wr_ready_i | input | 1 | Write accepted |
| unit_bytes_o | output | 6 | Bytes per unit for the current request |
| busy_o | output | 1 | Run in progress |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench goes after the stored count of zero. A design that took zero literally would move nothing, or would finish at once with transfer end set, where it should run the limited units and leave 0xFFFFFB. Every size code and step mode appears in random runs, and the reserved step code must leave the address fixed, not move it backwards. The bench also checks these corner cases:
- Source writes made in the middle of a run must be dropped.
- A global disable seen at a unit boundary must stop the run after exactly that unit.
- A run command must be refused while transfer end is set, and a misdecoded enable would start a run that should not happen.
- Clearing interrupt enable must drop the interrupt, and a design that latched it would keep it high.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int unsigned UNIT_MAX_BYTES = 32;
  localparam int unsigned DATA_W         = 8 * UNIT_MAX_BYTES;
  localparam int unsigned BYTES_W        = $clog2(UNIT_MAX_BYTES) + 1;

  localparam logic [1:0] RA_SRC  = 2'd0;
  localparam logic [1:0] RA_DST  = 2'd1;
  localparam logic [1:0] RA_CNT  = 2'd2;
  localparam logic [1:0] RA_CTRL = 2'd3;

  localparam int unsigned CB_EN   = 0;
  localparam int unsigned CB_TE   = 1;
  localparam int unsigned CB_IE   = 2;
  localparam int unsigned CB_SIZE = 4;
  localparam int unsigned CB_SMOD = 12;
  localparam int unsigned CB_DMOD = 14;

  typedef enum logic [1:0] {
    STEP_FIXED = 2'd0,
    STEP_INC   = 2'd1,
    STEP_DEC   = 2'd2,
    STEP_RSVD  = 2'd3
  } step_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RD   = 2'd1,
    SEQ_WR   = 2'd2
  } seq_e;

  function automatic logic [BYTES_W-1:0] unit_bytes(input logic [2:0] code);
    logic [BYTES_W-1:0] b;
    case (code)
      3'd0:    b = BYTES_W'(8);
      3'd2:    b = BYTES_W'(2);
      3'd3:    b = BYTES_W'(4);
      3'd4:    b = BYTES_W'(32);
      default: b = BYTES_W'(1);
    endcase
    return b;
  endfunction
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_chan_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  step_e              mode_i,
  input  logic [BYTES_W-1:0] bytes_i,
  output logic [ADDR_W-1:0]  next_o
);
  logic [ADDR_W-1:0] delta;
  assign delta = {{(ADDR_W-BYTES_W){1'b0}}, bytes_i};

  always_comb begin
    case (mode_i)
      STEP_INC: next_o = addr_i + delta;
      STEP_DEC: next_o = addr_i - delta;
      default:  next_o = addr_i;  // fixed and reserved
    endcase
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int unsigned REG_W  = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              busy_i,
  input  logic              unit_done_i,
  input  logic [ADDR_W-1:0] src_nxt_i,
  input  logic [ADDR_W-1:0] dst_nxt_i,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              chan_en_o,
  output logic [2:0]        size_code_o,
  output step_e             src_mode_o,
  output step_e             dst_mode_o,
  output logic              irq_o
);
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [REG_W-1:0]  ctrl_q, ctrl_d;
  logic              irq_q;
  logic              cnt_last, ctrl_wr;

  assign cnt_last = (cnt_q == CNT_W'(1));
  assign ctrl_wr  = we_i && (addr_i == RA_CTRL);

  always_comb begin
    ctrl_d = ctrl_wr ? wdata_i : ctrl_q;
    if (unit_done_i && cnt_last) ctrl_d[CB_TE] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      irq_q  <= ctrl_d[CB_IE] & ctrl_d[CB_TE];
      if (unit_done_i) begin
        src_q <= src_nxt_i;
        dst_q <= dst_nxt_i;
        cnt_q <= cnt_q - CNT_W'(1);
      end else if (we_i && !busy_i) begin
        case (addr_i)
          RA_SRC:  src_q <= wdata_i[ADDR_W-1:0];
          RA_DST:  dst_q <= wdata_i[ADDR_W-1:0];
          RA_CNT:  cnt_q <= wdata_i[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr_i)
      RA_SRC:  rdata_o = REG_W'(src_q);
      RA_DST:  rdata_o = REG_W'(dst_q);
      RA_CNT:  rdata_o = {{(REG_W-CNT_W){1'b0}}, cnt_q};
      default: rdata_o = ctrl_q;
    endcase
  end

  assign src_o       = src_q;
  assign dst_o       = dst_q;
  assign cnt_o       = cnt_q;
  assign chan_en_o   = ctrl_q[CB_EN] & ~ctrl_q[CB_TE];
  assign size_code_o = ctrl_q[CB_SIZE +: 3];
  assign src_mode_o  = step_e'(ctrl_q[CB_SMOD +: 2]);
  assign dst_mode_o  = step_e'(ctrl_q[CB_DMOD +: 2]);
  assign irq_o       = irq_q;

  // R8
  a_r8_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_done_i |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  a_r8_te_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unit_done_i && cnt_last) |=> ctrl_q[CB_TE]);
  // R2
  a_r2_hold_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !unit_done_i) |=> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q)));
  // R9
  a_r9_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(unit_done_i || ctrl_wr));
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             go_ok_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             rd_ready_i,
  input  logic             wr_ready_i,
  output logic             rd_valid_o,
  output logic             wr_valid_o,
  output logic             rd_fire_o,
  output logic             unit_done_o,
  output logic             busy_o
);
  localparam int unsigned LEFT_W = CNT_W + 1;

  seq_e              state_q;
  logic [LEFT_W-1:0] left_q, remain, lim_ext, units;
  logic              last_unit;

  assign remain  = (cnt_i == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, cnt_i};
  assign lim_ext = {1'b0, limit_i};
  assign units   = ((limit_i == '0) || (lim_ext > remain)) ? remain : lim_ext;

  assign last_unit = (left_q == LEFT_W'(1)) || (cnt_i == CNT_W'(1)) || !go_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      left_q  <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (run_i && go_ok_i) begin
          left_q  <= units;
          state_q <= SEQ_RD;
        end
        SEQ_RD: if (rd_ready_i) state_q <= SEQ_WR;
        SEQ_WR: if (wr_ready_i) begin
          left_q  <= left_q - LEFT_W'(1);
          state_q <= last_unit ? SEQ_IDLE : SEQ_RD;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign rd_valid_o  = (state_q == SEQ_RD);
  assign wr_valid_o  = (state_q == SEQ_WR);
  assign rd_fire_o   = rd_valid_o && rd_ready_i;
  assign unit_done_o = wr_valid_o && wr_ready_i;
  assign busy_o      = (state_q != SEQ_IDLE);

  // R6
  a_r6_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> rd_valid_o);
  a_r6_wr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> wr_valid_o);
  a_r6_rd_then_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_fire_o |=> (wr_valid_o && !rd_valid_o));
  // R7
  a_r7_left_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (left_q != '0));
  // R3
  a_r3_start_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(run_i && go_ok_i));
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int unsigned REG_W  = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  input  logic [2:0]         glob_ctrl_i,
  input  logic               run_i,
  input  logic [CNT_W-1:0]   run_limit_i,
  output logic               rd_valid_o,
  output logic [ADDR_W-1:0]  rd_addr_o,
  input  logic               rd_ready_i,
  input  logic [DATA_W-1:0]  rd_data_i,
  output logic               wr_valid_o,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [DATA_W-1:0]  wr_data_o,
  input  logic               wr_ready_i,
  output logic [BYTES_W-1:0] unit_bytes_o,
  output logic               busy_o,
  output logic               irq_o
);
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              chan_en, go_ok, rd_fire, unit_done;
  logic [2:0]        size_code;
  step_e             src_mode, dst_mode;
  logic [DATA_W-1:0] data_q;

  step_e             st_mode [2];
  logic [ADDR_W-1:0] st_cur  [2];
  logic [ADDR_W-1:0] st_next [2];

  assign go_ok        = (glob_ctrl_i == 3'b001) && chan_en;
  assign unit_bytes_o = unit_bytes(size_code);

  dma_chan_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_i(busy_o), .unit_done_i(unit_done),
    .src_nxt_i(st_next[0]), .dst_nxt_i(st_next[1]),
    .src_o(src_q), .dst_o(dst_q), .cnt_o(cnt_q),
    .chan_en_o(chan_en), .size_code_o(size_code),
    .src_mode_o(src_mode), .dst_mode_o(dst_mode), .irq_o
  );

  dma_chan_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i, .rst_ni,
    .run_i, .limit_i(run_limit_i), .go_ok_i(go_ok), .cnt_i(cnt_q),
    .rd_ready_i, .wr_ready_i,
    .rd_valid_o, .wr_valid_o, .rd_fire_o(rd_fire), .unit_done_o(unit_done), .busy_o
  );

  assign st_mode[0] = src_mode;
  assign st_mode[1] = dst_mode;
  assign st_cur[0]  = src_q;
  assign st_cur[1]  = dst_q;

  for (genvar g = 0; g < 2; g++) begin : g_step
    dma_addr_step #(.ADDR_W(ADDR_W)) u_step (
      .addr_i(st_cur[g]), .mode_i(st_mode[g]), .bytes_i(unit_bytes_o), .next_o(st_next[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (rd_fire) data_q <= rd_data_i;
  end

  assign rd_addr_o = src_q;
  assign wr_addr_o = dst_q;
  assign wr_data_o = data_q;

  // R6
  a_r6_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> $stable(rd_addr_o));
  // R10
  a_r10_boundary_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unit_done && !go_ok) |=> !busy_o);
  // R3
  a_r3_glob_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(glob_ctrl_i == 3'b001));
endmodule

// File: tb/dma_chan_engine_test.sv
`timescale 1ns/1ps
module dma_chan_engine_test;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         reg_we_i = 1'b0;
  logic [1:0]   reg_addr_i = '0;
  logic [31:0]  reg_wdata_i = '0;
  logic [31:0]  reg_rdata_o;
  logic [2:0]   glob_ctrl_i = 3'b001;
  logic         run_i = 1'b0;
  logic [23:0]  run_limit_i = '0;
  logic         rd_valid_o, wr_valid_o, rd_ready_i = 1'b0, wr_ready_i = 1'b0;
  logic [31:0]  rd_addr_o, wr_addr_o;
  logic [255:0] rd_data_i = '0, wr_data_o;
  logic [5:0]   unit_bytes_o;
  logic         busy_o, irq_o;

  int tests_run = 0, tests_failed = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_chan_engine uut (
    .clk_i(clk), .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .glob_ctrl_i, .run_i, .run_limit_i,
    .rd_valid_o, .rd_addr_o, .rd_ready_i, .rd_data_i,
    .wr_valid_o, .wr_addr_o, .wr_data_o, .wr_ready_i,
    .unit_bytes_o, .busy_o, .irq_o
  );

  task automatic chk(input string req, input string what, input logic [255:0] act, input logic [255:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] f_bytes(input logic [2:0] c);
    case (c)
      3'd0: return 6'd8;
      3'd2: return 6'd2;
      3'd3: return 6'd4;
      3'd4: return 6'd32;
      default: return 6'd1;
    endcase
  endfunction

  function automatic logic [31:0] f_step(input logic [31:0] a, input logic [1:0] m, input logic [5:0] b);
    if (m == 2'd1) return a + {26'd0, b};
    if (m == 2'd2) return a - {26'd0, b};
    return a;
  endfunction

  function automatic logic [31:0] f_ctrl(input logic [1:0] dm, input logic [1:0] sm,
                                          input logic [2:0] code, input logic ie, input logic te);
    return {16'd0, dm, sm, 5'd0, code, 1'b0, ie, te, 1'b1};
  endfunction

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #0.5;
    d = reg_rdata_o;
  endtask

  task automatic start_run(input logic [23:0] lim);
    @(negedge clk);
    run_i = 1'b1; run_limit_i = lim;
    @(negedge clk);
    run_i = 1'b0;
  endtask

  // one unit: read handshake then write handshake, checked at the ports
  task automatic do_unit(input logic [31:0] es, input logic [31:0] ed, input logic [5:0] eb,
                         input int rdly, input int wdly, input string req);
    logic [255:0] d;
    int n = 0;
    while (!rd_valid_o && n < 50) begin @(negedge clk); n++; end
    chk(req, "rd_valid", rd_valid_o, 1'b1);
    chk("R5", "rd_addr", rd_addr_o, es);
    chk("R4", "unit_bytes", unit_bytes_o, eb);
    chk("R6", "no wr with rd", wr_valid_o, 1'b0);
    repeat (rdly) @(negedge clk);
    chk("R6", "rd held", {rd_valid_o, rd_addr_o}, {1'b1, es});
    d = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
    rd_data_i = d; rd_ready_i = 1'b1;
    @(negedge clk);
    rd_ready_i = 1'b0;
    chk("R6", "wr after rd", {wr_valid_o, rd_valid_o}, 2'b10);
    repeat (wdly) @(negedge clk);
    chk("R5", "wr_addr", wr_addr_o, ed);
    chk("R6", "wr_data", wr_data_o, d);
    wr_ready_i = 1'b1;
    @(negedge clk);
    wr_ready_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests_run++; tests_failed++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, src, dst, es, ed;
    logic [23:0] cnt, lim, units;
    logic [2:0]  code;
    logic [1:0]  sm, dm;
    logic        ie;
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      reg_rd(a[1:0], v); chk("R1", "reg after reset", v, 32'd0);
    end
    chk("R1", "outputs after reset", {busy_o, rd_valid_o, wr_valid_o, irq_o}, 4'b0);
    @(negedge clk); rst_ni = 1'b1;

    // R2 count keeps 24 bits
    reg_wr(2'd2, 32'hFF00_0005);
    reg_rd(2'd2, v); chk("R2", "count width", v, 32'h0000_0005);

    // R3 wrong global code, no start
    reg_wr(2'd3, f_ctrl(2'd1, 2'd1, 3'd1, 1'b0, 1'b0));
    glob_ctrl_i = 3'b011;
    start_run(24'd1);
    chk("R3", "no run when global 011", {busy_o, rd_valid_o}, 2'b00);
    glob_ctrl_i = 3'b001;

    // R7 count 0 means 2^24, limit 5; R2 src write while busy ignored; R5 reserved mode fixed
    reg_wr(2'd0, 32'h1000_0000);
    reg_wr(2'd1, 32'h2000_0000);
    reg_wr(2'd2, 32'd0);
    reg_wr(2'd3, f_ctrl(2'd3, 2'd1, 3'd6, 1'b0, 1'b0));
    start_run(24'd5);
    reg_wr(2'd0, 32'hDEAD_0000);
    es = 32'h1000_0000;
    for (int u = 0; u < 5; u++) begin
      do_unit(es, 32'h2000_0000, 6'd1, u % 3, 1, "R7");
      es = es + 32'd1;
    end
    chk("R7", "stopped at limit", busy_o, 1'b0);
    reg_rd(2'd2, v); chk("R7", "count from zero", v, 32'h00FF_FFFB);
    reg_rd(2'd0, v); chk("R2", "src ignored while busy", v, 32'h1000_0005);
    reg_rd(2'd1, v); chk("R5", "reserved dst mode fixed", v, 32'h2000_0000);
    reg_rd(2'd3, v); chk("R8", "te clear", v[1], 1'b0);

    // R10 global disable at boundary
    reg_wr(2'd0, 32'h0000_4000);
    reg_wr(2'd2, 32'd5);
    reg_wr(2'd3, f_ctrl(2'd0, 2'd2, 3'd3, 1'b1, 1'b0));
    start_run(24'd0);
    do_unit(32'h0000_4000, 32'h2000_0000, 6'd4, 0, 0, "R10");
    glob_ctrl_i = 3'b000;
    do_unit(32'h0000_3FFC, 32'h2000_0000, 6'd4, 1, 0, "R10");
    chk("R10", "stop after disable", busy_o, 1'b0);
    reg_rd(2'd2, v); chk("R10", "count after stop", v, 32'd3);
    glob_ctrl_i = 3'b001;
    start_run(24'd0);
    es = 32'h0000_3FF8;
    for (int u = 0; u < 3; u++) begin
      do_unit(es, 32'h2000_0000, 6'd4, 0, 1, "R8");
      es = es - 32'd4;
    end
    chk("R8", "stop at count end", busy_o, 1'b0);
    reg_rd(2'd3, v); chk("R8", "te set", v[1], 1'b1);
    chk("R9", "irq raised", irq_o, 1'b1);
    // R3 te set blocks a new run
    reg_wr(2'd2, 32'd2);
    start_run(24'd0);
    chk("R3", "no run with te", busy_o, 1'b0);
    reg_wr(2'd3, f_ctrl(2'd0, 2'd2, 3'd3, 1'b0, 1'b1));
    chk("R9", "irq dropped on ie clear", irq_o, 1'b0);

    // random runs
    for (int t = 0; t < 30; t++) begin
      src = $urandom(); dst = $urandom();
      code = 3'($urandom() % 8); sm = 2'($urandom() % 4); dm = 2'($urandom() % 4);
      cnt = 24'(1 + $urandom() % 6); lim = 24'($urandom() % 8); ie = 1'($urandom() % 2);
      units = (lim == 0 || lim > cnt) ? cnt : lim;
      reg_wr(2'd3, 32'd0);
      reg_wr(2'd0, src); reg_wr(2'd1, dst); reg_wr(2'd2, {8'd0, cnt});
      reg_wr(2'd3, f_ctrl(dm, sm, code, ie, 1'b0));
      start_run(lim);
      es = src; ed = dst;
      for (int u = 0; u < int'(units); u++) begin
        do_unit(es, ed, f_bytes(code), $urandom() % 3, $urandom() % 3, "R4");
        es = f_step(es, sm, f_bytes(code));
        ed = f_step(ed, dm, f_bytes(code));
      end
      chk("R7", "idle after units", busy_o, 1'b0);
      reg_rd(2'd0, v); chk("R5", "src writeback", v, es);
      reg_rd(2'd1, v); chk("R5", "dst writeback", v, ed);
      reg_rd(2'd2, v); chk("R8", "count writeback", v, {8'd0, cnt - units});
      reg_rd(2'd3, v); chk("R8", "te flag", v[1], units == cnt);
      chk("R9", "irq level", irq_o, ie && (units == cnt));
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule